// File: doc/BRIEF.md
# Indexed Block Register Target for SMBus

This block is a target on a two-wire SMBus segment. It serves nine control bytes to the clock-control logic around it. SCL and SDA arrive already synchronised to a faster system clock. The block watches them for START and STOP conditions, shifts bytes in on the rising edge of SCL, and pulls SDA low through an open-drain enable to acknowledge or to send data.

A host writes with a block write. The host sends the target address with the write bit, a starting index, a byte count and then that many data bytes. The target acknowledges each byte and stores it at successive indices. A host reads by sending the address with the write bit and a starting index, then a repeated START and the address with the read bit. The target replies with a byte-count byte and then register contents from the starting index for as long as the host acknowledges. A write-lock input discards stored writes without disturbing the bus exchange. A strap input chooses one of two device-identity codes. Every register's read value is driven to the neighbouring logic as a flat image.

Top module: `smb_blk_target`

## Requirements
- R1: The target responds only to the 7-bit address 1101100, sent MSB first and followed by the R/W bit (0 = write, 1 = read). Write is byte 0xD8 and read is 0xD9. For any other address it leaves SDA released for the ACK bit and for every remaining bit until the next START.
- R2: In a block write (index N, count X), every byte up to and including the X-th data byte is acknowledged. Data byte k is stored at index N+k. A data byte beyond the X-th is not acknowledged, and the target then stays silent.
- R3: After a repeated START and the read address, the target first sends the low 5 bits of register 7 (upper 3 bits 0) as a count byte. It then sends register N, N+1 and so on, MSB first, for as long as the host acknowledges. A host NACK ends the transmission.
- R4: While wr_lock_i is 1 at the moment a data byte completes, the byte is still acknowledged but is not stored. Reads are unaffected. A byte that completes while the lock is 0 is stored.
- R5: Register 7 resets to 0x08. Only its low 5 bits are writable.
- R6: Register 5 always reads 0x41 (revision nibble 0100 above vendor nibble 0001) and ignores writes.
- R7: Register 6 reads 0xE6 when dev_sel_i is 0 and 0xF6 when it is 1, and ignores writes.
- R8: Writable bit masks and reset values are: register 0 mask 0x0E, reset 0x00; register 1 mask 0xF6, reset 0xF6; register 2 mask 0x06, reset 0x06. Registers 3, 4 and 8 and every bit outside a mask read 0.
- R9: The index advances by one after every data byte, in both directions. An index of 9 or more reads 0x00 and ignores writes.
- R10: A STOP at any point returns the target to idle. A START after two or more data bits of a byte have been clocked aborts the transfer, so nothing further is acknowledged or stored until the next START. A START at a byte boundary (at most one SCL rise into the byte) is a repeated START.
- R11: After reset SDA is released, and reg_image_o byte i (bits 8i+7..8i) always equals the read value of register i.
- R12: The target never begins pulling SDA low while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA line level |
| wr_lock_i | input | 1 | 1 blocks storage of written data |
| dev_sel_i | input | 1 | Identity strap: 0 selects 0xE6, 1 selects 0xF6 |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| reg_image_o | output | 72 | Read values of registers 0..8, byte i at bits 8i+7..8i |

## Verification
Two things can fall on the same data byte: the write lock changing, and the commit of that byte into the register file. The bench raises the lock between two data bytes of a single block write. The first byte must then land in the image and the second must not, while both bytes are still acknowledged. The boundary between a repeated START and an aborting START is provoked the same way. A START placed right after the index ACK must be taken as a restart. A START four bits into a data byte must leave the target silent, with the register untouched.

// File: rtl/smb_tgt_pkg.sv
package smb_tgt_pkg;

    localparam int NREG = 9;
    localparam logic [6:0] TGT_ADDR_DFLT = 7'b1101100;
    localparam int CNT_REG = 7;
    localparam int ID_REG  = 5;
    localparam int DEV_REG = 6;
    localparam logic [7:0] REV_VEND = 8'h41;
    localparam logic [7:0] DEVID_LO = 8'hE6;
    localparam logic [7:0] DEVID_HI = 8'hF6;

    typedef enum logic [2:0] {
        PH_IDLE, PH_ADDR, PH_INDEX, PH_COUNT,
        PH_WDATA, PH_RCOUNT, PH_RDATA, PH_IGNORE
    } phase_e;

    function automatic logic [7:0] wr_mask(input int i);
        case (i)
            0:       return 8'h0E;
            1:       return 8'hF6;
            2:       return 8'h06;
            7:       return 8'h1F;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] rst_val(input int i);
        case (i)
            1:       return 8'hF6;
            2:       return 8'h06;
            7:       return 8'h08;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/smb_line_events.sv
module smb_line_events (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic scl_steady_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise_o   = scl_i & ~scl_q;
    assign scl_fall_o   = ~scl_i & scl_q;
    assign scl_steady_o = scl_i & scl_q;
    assign start_o      = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_o       = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
    import smb_tgt_pkg::*;
#(
    parameter int IDXW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic              wr_lock_i,
    input  logic [IDXW-1:0]   wr_idx_i,
    input  logic [7:0]        wdata_i,
    input  logic [IDXW-1:0]   rd_idx_i,
    input  logic              dev_sel_i,
    output logic [7:0]        rdata_o,
    output logic [8*NREG-1:0] image_o
);
    logic [7:0] store [NREG];
    logic [7:0] view  [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) store[i] <= rst_val(i);
        end else if (wr_en_i && !wr_lock_i) begin
            for (int i = 0; i < NREG; i++) begin
                if (wr_idx_i == IDXW'(i)) store[i] <= wdata_i & wr_mask(i);
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NREG; i++) view[i] = store[i];
        view[ID_REG]  = REV_VEND;
        view[DEV_REG] = dev_sel_i ? DEVID_HI : DEVID_LO;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_img
        assign image_o[8*g +: 8] = view[g];
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NREG; i++) begin
            if (rd_idx_i == IDXW'(i)) rdata_o = view[i];
        end
    end

    AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_lock_i && $stable(dev_sel_i)) |=> $stable(image_o)); // R4
    AST_OOR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_idx_i >= IDXW'(NREG) && $stable(dev_sel_i)) |=> $stable(image_o)); // R9

endmodule

// File: rtl/smb_xfer_ctrl.sv
module smb_xfer_ctrl
    import smb_tgt_pkg::*;
#(
    parameter logic [6:0] ADDR = TGT_ADDR_DFLT,
    parameter int         IDXW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            scl_rise_i,
    input  logic            scl_fall_i,
    input  logic            scl_steady_i,
    input  logic            start_i,
    input  logic            stop_i,
    input  logic            sda_i,
    input  logic [7:0]      rdata_i,
    input  logic [7:0]      cnt_byte_i,
    output logic [IDXW-1:0] rd_idx_o,
    output logic [IDXW-1:0] wr_idx_o,
    output logic [7:0]      wdata_o,
    output logic            wr_en_o,
    output logic            sda_oe_o
);
    phase_e          phase, nxt_ph;
    logic [3:0]      bitcnt;
    logic [7:0]      shreg, txbyte, remain;
    logic [IDXW-1:0] idx, idx_inc;
    logic            host_nack;
    logic            tx, active;
    logic [2:0]      bsel;

    assign tx       = (phase == PH_RCOUNT) || (phase == PH_RDATA);
    assign active   = (phase != PH_IDLE) && (phase != PH_IGNORE);
    assign idx_inc  = (idx == '1) ? idx : idx + 1'b1;
    assign bsel     = 3'(4'd7 - bitcnt);
    assign rd_idx_o = idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            nxt_ph    <= PH_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            txbyte    <= '0;
            remain    <= '0;
            idx       <= '0;
            host_nack <= 1'b0;
            sda_oe_o  <= 1'b0;
            wr_en_o   <= 1'b0;
            wr_idx_o  <= '0;
            wdata_o   <= '0;
        end else begin
            wr_en_o <= 1'b0;
            if (stop_i) begin
                phase    <= PH_IDLE;
                bitcnt   <= '0;
                sda_oe_o <= 1'b0;
            end else if (start_i) begin
                bitcnt   <= '0;
                sda_oe_o <= 1'b0;
                phase    <= (active && bitcnt >= 4'd2) ? PH_IDLE : PH_ADDR;
            end else if (active) begin
                if (scl_rise_i) begin
                    if (bitcnt < 4'd8) begin
                        shreg  <= {shreg[6:0], sda_i};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (bitcnt == 4'd8) begin
                        bitcnt    <= 4'd9;
                        host_nack <= sda_i;
                    end
                end else if (scl_fall_i) begin
                    if (!tx) begin
                        if (bitcnt == 4'd8) begin
                            case (phase)
                                PH_ADDR: begin
                                    if (shreg[7:1] == ADDR) begin
                                        sda_oe_o <= 1'b1;
                                        nxt_ph   <= shreg[0] ? PH_RCOUNT : PH_INDEX;
                                    end else begin
                                        phase <= PH_IGNORE;
                                    end
                                end
                                PH_INDEX: begin
                                    idx      <= IDXW'(shreg);
                                    sda_oe_o <= 1'b1;
                                    nxt_ph   <= PH_COUNT;
                                end
                                PH_COUNT: begin
                                    remain   <= shreg;
                                    sda_oe_o <= 1'b1;
                                    nxt_ph   <= PH_WDATA;
                                end
                                PH_WDATA: begin
                                    if (remain != 8'd0) begin
                                        wr_en_o  <= 1'b1;
                                        wr_idx_o <= idx;
                                        wdata_o  <= shreg;
                                        idx      <= idx_inc;
                                        remain   <= remain - 8'd1;
                                        sda_oe_o <= 1'b1;
                                        nxt_ph   <= PH_WDATA;
                                    end else begin
                                        phase <= PH_IGNORE;
                                    end
                                end
                                default: phase <= PH_IGNORE;
                            endcase
                        end else if (bitcnt == 4'd9) begin
                            bitcnt   <= '0;
                            phase    <= nxt_ph;
                            sda_oe_o <= 1'b0;
                            if (nxt_ph == PH_RCOUNT) begin
                                txbyte   <= cnt_byte_i;
                                sda_oe_o <= ~cnt_byte_i[7];
                            end
                        end
                    end else begin
                        if (bitcnt >= 4'd1 && bitcnt <= 4'd7) begin
                            sda_oe_o <= ~txbyte[bsel];
                        end else if (bitcnt == 4'd8) begin
                            sda_oe_o <= 1'b0;
                        end else if (bitcnt == 4'd9) begin
                            bitcnt <= '0;
                            if (!host_nack) begin
                                txbyte   <= rdata_i;
                                idx      <= idx_inc;
                                phase    <= PH_RDATA;
                                sda_oe_o <= ~rdata_i[7];
                            end else begin
                                phase    <= PH_IGNORE;
                                sda_oe_o <= 1'b0;
                            end
                        end
                    end
                end
            end
        end
    end

    AST_SILENT_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!active) |-> !sda_oe_o); // R1
    AST_RX_ACK_SLOT: assert property (@(posedge clk) disable iff (rst)
        (sda_oe_o && active && !tx) |-> (bitcnt >= 4'd8)); // R2
    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst)
        stop_i |=> !sda_oe_o); // R10
    AST_NO_PULL_ON_HIGH: assert property (@(posedge clk) disable iff (rst)
        (scl_steady_i && $past(scl_steady_i)) |-> !$rose(sda_oe_o)); // R12

endmodule

// File: rtl/smb_blk_target.sv
module smb_blk_target
    import smb_tgt_pkg::*;
#(
    parameter logic [6:0] ADDR = TGT_ADDR_DFLT,
    parameter int         IDXW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              wr_lock_i,
    input  logic              dev_sel_i,
    output logic              sda_oe_o,
    output logic [8*NREG-1:0] reg_image_o
);
    logic            scl_rise, scl_fall, scl_steady, start_evt, stop_evt;
    logic [IDXW-1:0] rd_idx, wr_idx;
    logic [7:0]      rdata, wdata;
    logic            wr_en;

    smb_line_events u_events (
        .clk          (clk),
        .rst          (rst),
        .scl_i        (scl_i),
        .sda_i        (sda_i),
        .scl_rise_o   (scl_rise),
        .scl_fall_o   (scl_fall),
        .scl_steady_o (scl_steady),
        .start_o      (start_evt),
        .stop_o       (stop_evt)
    );

    smb_xfer_ctrl #(.ADDR(ADDR), .IDXW(IDXW)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .scl_rise_i   (scl_rise),
        .scl_fall_i   (scl_fall),
        .scl_steady_i (scl_steady),
        .start_i      (start_evt),
        .stop_i       (stop_evt),
        .sda_i        (sda_i),
        .rdata_i      (rdata),
        .cnt_byte_i   (reg_image_o[8*CNT_REG +: 8]),
        .rd_idx_o     (rd_idx),
        .wr_idx_o     (wr_idx),
        .wdata_o      (wdata),
        .wr_en_o      (wr_en),
        .sda_oe_o     (sda_oe_o)
    );

    smb_reg_bank #(.IDXW(IDXW)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en),
        .wr_lock_i (wr_lock_i),
        .wr_idx_i  (wr_idx),
        .wdata_i   (wdata),
        .rd_idx_i  (rd_idx),
        .dev_sel_i (dev_sel_i),
        .rdata_o   (rdata),
        .image_o   (reg_image_o)
    );

endmodule

// File: tb/smb_blk_target_bench.sv
module smb_blk_target_bench;
    localparam int Q = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_h = 1'b1;
    logic        sda_h = 1'b1;
    logic        lock = 1'b0;
    logic        dsel = 1'b0;
    logic        sda_oe;
    logic [71:0] image;
    wire         sda_line = sda_h & ~sda_oe;

    int tests = 0;
    int fails = 0;
    int r12_bad = 0;
    logic scl_d = 1'b1, oe_d = 1'b0;
    logic [7:0] mdl  [9];
    logic [7:0] wbuf [16];
    logic [7:0] rbuf [16];

    always #10 clk = ~clk;

    smb_blk_target u_smb_blk_target (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (scl_h),
        .sda_i       (sda_line),
        .wr_lock_i   (lock),
        .dev_sel_i   (dsel),
        .sda_oe_o    (sda_oe),
        .reg_image_o (image)
    );

    // R12 monitor: SDA pull may only start while SCL is low
    always @(posedge clk) begin
        if (!rst && scl_h && scl_d && sda_oe && !oe_d) r12_bad <= r12_bad + 1;
        scl_d <= scl_h;
        oe_d  <= sda_oe;
    end

    function automatic logic [7:0] bmask(input int i);
        case (i)
            0: return 8'h0E;
            1: return 8'hF6;
            2: return 8'h06;
            7: return 8'h1F;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] ev(input int i);
        if (i == 5) return 8'h41;
        if (i == 6) return dsel ? 8'hF6 : 8'hE6;
        if (i < 9) return mdl[i];
        return 8'h00;
    endfunction

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic hw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        sda_h = b; hw(Q); scl_h = 1'b1; hw(2*Q); scl_h = 1'b0; hw(Q);
    endtask

    task automatic bit_in(output logic b);
        sda_h = 1'b1; hw(Q); scl_h = 1'b1; hw(Q); b = sda_line; hw(Q); scl_h = 1'b0; hw(Q);
    endtask

    task automatic do_start();
        sda_h = 1'b1; hw(Q); scl_h = 1'b1; hw(Q); sda_h = 1'b0; hw(Q); scl_h = 1'b0; hw(Q);
    endtask

    task automatic do_stop();
        sda_h = 1'b0; hw(Q); scl_h = 1'b1; hw(Q); sda_h = 1'b1; hw(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic a;
        for (int k = 7; k >= 0; k--) bit_out(d[k]);
        bit_in(a);
        ack = ~a;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic give_ack);
        logic b;
        for (int k = 7; k >= 0; k--) begin
            bit_in(b);
            d[k] = b;
        end
        bit_out(~give_ack);
    endtask

    task automatic blk_write(input logic [7:0] n, input logic [7:0] x, input int nsend, output int acks);
        logic a;
        acks = 0;
        do_start();
        send_byte(8'hD8, a); acks += int'(a);
        send_byte(n, a);     acks += int'(a);
        send_byte(x, a);     acks += int'(a);
        for (int k = 0; k < nsend; k++) begin
            send_byte(wbuf[k], a);
            acks += int'(a);
        end
        do_stop();
    endtask

    task automatic blk_read(input logic [7:0] n, input int nb, output logic [7:0] cb, output int acks);
        logic a;
        acks = 0;
        do_start();
        send_byte(8'hD8, a); acks += int'(a);
        send_byte(n, a);     acks += int'(a);
        do_start();
        send_byte(8'hD9, a); acks += int'(a);
        recv_byte(cb, nb != 0);
        for (int k = 0; k < nb; k++) recv_byte(rbuf[k], k != nb - 1);
        do_stop();
    endtask

    task automatic model_write(input int n, input int x);
        for (int k = 0; k < x; k++) begin
            if (n + k < 9) mdl[n + k] = wbuf[k] & bmask(n + k);
        end
    endtask

    task automatic chk_image(input string rq);
        for (int i = 0; i < 9; i++) chk(rq, $sformatf("image byte %0d", i), 32'(image[8*i +: 8]), 32'(ev(i)));
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        int acks;
        logic [7:0] cb;
        logic a;
        for (int i = 0; i < 9; i++) mdl[i] = 8'h00;
        mdl[1] = 8'hF6; mdl[2] = 8'h06; mdl[7] = 8'h08;
        hw(5);
        rst = 1'b0;
        hw(3);

        // R11 R5 R8: reset state
        chk("R11", "sda released after reset", 32'(sda_oe), 32'd0);
        chk_image("R11");

        // R3 R5 R6 R7 R8: default read of all bytes
        blk_read(8'd0, 9, cb, acks);
        chk("R3", "read acks", 32'(acks), 32'd3);
        chk("R5", "default count byte", 32'(cb), 32'h08);
        for (int i = 0; i < 9; i++) chk("R3", $sformatf("default read %0d", i), 32'(rbuf[i]), 32'(ev(i)));

        // R1: every 7-bit address
        for (int ad = 0; ad < 128; ad++) begin
            do_start();
            send_byte({7'(ad), 1'b0}, a);
            if (ad != 7'h6C) send_byte(8'h00, a);
            chk("R1", $sformatf("address %0h ack", ad), 32'(a), 32'(ad == 7'h6C));
            do_stop();
        end

        // R2 R3 R8 R9: sweep of patterns across all registers
        for (int p = 0; p < 6; p++) begin
            logic [7:0] pat;
            pat = 8'(p * 8'h47) ^ 8'hA5;
            for (int k = 0; k < 9; k++) wbuf[k] = pat ^ 8'(k * 8'h1D);
            blk_write(8'd0, 8'd9, 9, acks);
            model_write(0, 9);
            chk("R2", "sweep write acks", 32'(acks), 32'd12);
            chk_image("R8");
            blk_read(8'd0, 11, cb, acks);
            chk("R3", "sweep count byte", 32'(cb), 32'(mdl[7] & 8'h1F));
            for (int i = 0; i < 11; i++) chk("R9", $sformatf("sweep read %0d", i), 32'(rbuf[i]), 32'(ev(i)));
        end

        // R2: byte past the count is refused and not stored
        wbuf[0] = 8'hFF; wbuf[1] = 8'hFF; wbuf[2] = 8'hFF;
        blk_write(8'd1, 8'd2, 3, acks);
        model_write(1, 2);
        chk("R2", "extra byte refused", 32'(acks), 32'd5);
        chk_image("R2");

        // R4: lock raised between two bytes of one write
        do_start();
        send_byte(8'hD8, a); send_byte(8'd1, a); send_byte(8'd2, a);
        send_byte(8'h00, a);
        chk("R4", "first byte ack", 32'(a), 32'd1);
        lock = 1'b1;
        send_byte(8'h00, a);
        chk("R4", "locked byte still acked", 32'(a), 32'd1);
        do_stop();
        mdl[1] = 8'h00;
        chk_image("R4");
        blk_read(8'd1, 2, cb, acks);
        chk("R4", "read while locked", 32'(rbuf[1]), 32'(ev(2)));
        lock = 1'b0;

        // R9: index past the end
        wbuf[0] = 8'hAA; wbuf[1] = 8'h55; wbuf[2] = 8'h33;
        blk_write(8'd8, 8'd3, 3, acks);
        chk("R9", "out of range acks", 32'(acks), 32'd6);
        chk_image("R9");
        blk_read(8'd7, 5, cb, acks);
        for (int i = 0; i < 5; i++) chk("R9", $sformatf("read from 7 +%0d", i), 32'(rbuf[i]), 32'(ev(7 + i)));

        // R6 R7: read-only identity bytes and strap
        dsel = 1'b1;
        wbuf[0] = 8'h00; wbuf[1] = 8'h00;
        blk_write(8'd5, 8'd2, 2, acks);
        blk_read(8'd5, 2, cb, acks);
        chk("R6", "revision/vendor byte", 32'(rbuf[0]), 32'h41);
        chk("R7", "identity with strap 1", 32'(rbuf[1]), 32'hF6);
        dsel = 1'b0;
        hw(2);
        chk("R7", "identity with strap 0", 32'(image[8*6 +: 8]), 32'hE6);

        // R10: START four bits into a data byte aborts
        do_start();
        send_byte(8'hD8, a); send_byte(8'd0, a); send_byte(8'd1, a);
        for (int k = 0; k < 4; k++) bit_out(1'b1);
        do_start();
        for (int k = 0; k < 4; k++) bit_out(1'b1);
        bit_in(a);
        chk("R10", "no ack after mid-byte START", 32'(a), 32'd1);
        send_byte(8'hFF, a);
        chk("R10", "still silent", 32'(a), 32'd0);
        do_stop();
        chk_image("R10");

        // R10: STOP mid-byte, then a normal read works
        do_start();
        send_byte(8'hD8, a); send_byte(8'd0, a); send_byte(8'd1, a);
        for (int k = 0; k < 3; k++) bit_out(1'b1);
        do_stop();
        blk_read(8'd0, 1, cb, acks);
        chk("R10", "transfer after mid-byte STOP", 32'(acks), 32'd3);
        chk("R10", "register 0 unchanged", 32'(rbuf[0]), 32'(ev(0)));

        // R5: count register upper bits masked
        wbuf[0] = 8'hE3;
        blk_write(8'd7, 8'd1, 1, acks);
        model_write(7, 1);
        blk_read(8'd7, 1, cb, acks);
        chk("R5", "count byte after write", 32'(cb), 32'h03);
        chk("R5", "register 7 value", 32'(rbuf[0]), 32'h03);

        chk("R12", "SDA pulls started while SCL high", 32'(r12_bad), 32'd0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule